// File: doc/BRIEF.md
# Hub Downstream Port Event Detector

This block watches the line state of one downstream port of a hub. The line state arrives as a two-bit code sampled on the system clock. The block keeps a record of whether a device is attached. It emits single-cycle pulses when a device connects or disconnects, and it notices when a suspended device signals resume by holding K. On resume it raises a request to rebroadcast resume upstream. In the same cycle it starts driving K back onto the port for a long fixed interval.

All timing windows are given in nanoseconds and converted to clock-cycle constants at elaboration from the clock frequency parameter (in kHz). Each conversion rounds up. Connect and disconnect use one window while the hub is awake and a longer one while it is suspended. Each window counts unbroken cycles of one line value, so any change of the sampled code restarts the count. A disconnect seen while resume is being driven ends the drive at once.

Top module: `hub_dport_evt`

## Requirements
- R1: While reset is held and on the first cycle after it, all four outputs are low and the port is treated as detached.
- R2: While detached with the hub awake, a code other than SE0 (line code 2'b00) held for CA cycles gives exactly one `conn_evt_o` pulse. CA is CONN_AWAKE_NS rounded up to whole cycles. The pulse is seen in the cycle after the CA-th sampling edge of that code, and shorter holds give no pulse.
- R3: While detached with the hub suspended, the connect threshold is CS cycles, taken from CONN_SUSP_NS in the same way as R2.
- R4: While attached with the hub awake, SE0 held for DA cycles (from DISC_AWAKE_NS) gives one `disc_evt_o` pulse and the port becomes detached. Shorter SE0 holds give none.
- R5: While attached with the hub suspended, the disconnect threshold is DS cycles (from DISC_SUSP_NS).
- R6: Any change of the sampled code before a threshold is reached restarts that threshold's count. This includes a change between J (2'b01) and K (2'b10).
- R7: Resume is detected when the port is attached, the port is enabled, the hub is suspended, no drive is in progress, and K (2'b10) has been held for RD cycles (from RSM_DET_NS). On detection, `rsm_bcast_o` pulses and `rsm_drive_o` rises in the same cycle, which is the cycle after the RD-th edge.
- R8: `rsm_drive_o` then stays high for exactly DR cycles (from RSM_DRIVE_NS). K that keeps being held after the drive ends starts no new resume.
- R9: A K hold of at least RD cycles gives no resume when the hub is awake, when the port is disabled, or when the port is detached at the moment the count reaches RD.
- R10: A disconnect detected during the drive ends the drive. `rsm_drive_o` is already low in the cycle that shows `disc_evt_o`.
- R11: `conn_evt_o`, `disc_evt_o` and `rsm_bcast_o` are each high for one cycle at a time, and connect and disconnect never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_st_i | input | 2 | Sampled line code: 00 SE0, 01 J, 10 K, 11 invalid (treated as non-SE0) |
| hub_awake_i | input | 1 | 1 while the hub is awake, 0 while it is suspended |
| port_en_i | input | 1 | Port enabled flag |
| conn_evt_o | output | 1 | Connect event pulse |
| disc_evt_o | output | 1 | Disconnect event pulse |
| rsm_bcast_o | output | 1 | Request to rebroadcast resume upstream (pulse) |
| rsm_drive_o | output | 1 | Drive K onto the port (level) |

## Verification
The assertions assume that the line code, the awake flag and the enable flag are synchronous to the clock and stable for whole cycles. They also assume that the awake flag does not change in the middle of a count it selects a threshold for. The stimulus changes every input just after a clock edge. It changes the awake and enable flags only while the line rests in a state whose count cannot reach a threshold during the trial. Hold lengths are swept around each threshold, from two cycles below it to one cycle above, and the port is reset before every trial so that each one starts detached.

// File: rtl/hub_dsp_pkg.sv
package hub_dsp_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_BAD = 2'b11
    } line_e;

    // Window length in ns -> whole clock cycles, rounded up, at least one.
    function automatic int unsigned ns_to_cyc(longint unsigned ns, longint unsigned khz);
        longint unsigned c;
        c = (ns * khz + 64'd999999) / 64'd1000000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hub_dsp_run.sv
// Registers the line code and counts consecutive cycles it has been held.
module hub_dsp_run #(
    parameter int unsigned RUN_CAP = 16,
    localparam int unsigned RUN_W  = $clog2(RUN_CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       line_i,
    output logic [1:0]       line_o,
    output logic [RUN_W-1:0] run_o
);
    typedef struct packed {
        logic [1:0]       line;
        logic [RUN_W-1:0] run;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.line = line_i;
        if (line_i != st_q.line) begin
            st_d.run = RUN_W'(1);
        end else if (st_q.run != RUN_W'(RUN_CAP)) begin
            st_d.run = st_q.run + RUN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{line: hub_dsp_pkg::LS_SE0, run: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o = st_q.line;
    assign run_o  = st_q.run;

    AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (line_i != line_o) |=> (run_o == RUN_W'(1))) else $error("run restart"); // R6
endmodule

// File: rtl/hub_dsp_attach.sv
// Attach tracking: connect and disconnect detection with awake/suspend windows.
module hub_dsp_attach #(
    parameter int unsigned CA = 5,
    parameter int unsigned CS = 10,
    parameter int unsigned DA = 5,
    parameter int unsigned DS = 8,
    parameter int unsigned RUN_CAP = 16,
    localparam int unsigned RUN_W = $clog2(RUN_CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       line_i,
    input  logic [RUN_W-1:0] run_i,
    input  logic             awake_i,
    output logic             attached_o,
    output logic             disc_fire_o,
    output logic             conn_o,
    output logic             disc_o
);
    typedef struct packed {
        logic attached;
        logic conn;
        logic disc;
    } att_st_t;

    att_st_t st_d, st_q;
    logic [RUN_W-1:0] conn_thr, disc_thr;
    logic             conn_fire, disc_fire;

    always_comb begin
        conn_thr  = awake_i ? RUN_W'(CA) : RUN_W'(CS);
        disc_thr  = awake_i ? RUN_W'(DA) : RUN_W'(DS);
        conn_fire = !st_q.attached && (line_i != hub_dsp_pkg::LS_SE0) && (run_i == conn_thr);
        disc_fire = st_q.attached && (line_i == hub_dsp_pkg::LS_SE0) && (run_i == disc_thr);
        st_d      = st_q;
        st_d.conn = conn_fire;
        st_d.disc = disc_fire;
        if (conn_fire) st_d.attached = 1'b1;
        if (disc_fire) st_d.attached = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign attached_o  = st_q.attached;
    assign disc_fire_o = disc_fire;
    assign conn_o      = st_q.conn;
    assign disc_o      = st_q.disc;

    AST_CONN_SETS_ATTACH: assert property (@(posedge clk) disable iff (!rst_n)
        conn_o |-> attached_o) else $error("connect without attach"); // R2
    AST_DISC_CLEARS_ATTACH: assert property (@(posedge clk) disable iff (!rst_n)
        disc_o |-> !attached_o) else $error("disconnect with attach"); // R4
endmodule

// File: rtl/hub_dsp_resume.sv
// Resume detection, upstream rebroadcast pulse and timed K drive.
module hub_dsp_resume #(
    parameter int unsigned RD = 5,
    parameter int unsigned DR = 40,
    parameter int unsigned RUN_CAP = 16,
    localparam int unsigned RUN_W = $clog2(RUN_CAP + 1),
    localparam int unsigned DRV_W = $clog2(DR + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       line_i,
    input  logic [RUN_W-1:0] run_i,
    input  logic             attached_i,
    input  logic             awake_i,
    input  logic             en_i,
    input  logic             abort_i,
    output logic             bcast_o,
    output logic             drive_o
);
    typedef struct packed {
        logic             drive;
        logic             bcast;
        logic [DRV_W-1:0] cnt;
    } rsm_st_t;

    rsm_st_t st_d, st_q;
    logic    start;

    always_comb begin
        start = attached_i && en_i && !awake_i && !st_q.drive
             && (line_i == hub_dsp_pkg::LS_K) && (run_i == RUN_W'(RD));
        st_d       = st_q;
        st_d.bcast = 1'b0;
        if (st_q.drive) begin
            if (abort_i || st_q.cnt == '0) begin
                st_d.drive = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt - DRV_W'(1);
            end
        end else if (start) begin
            st_d.drive = 1'b1;
            st_d.bcast = 1'b1;
            st_d.cnt   = DRV_W'(DR - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bcast_o = st_q.bcast;
    assign drive_o = st_q.drive;

    AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.drive && st_q.cnt != '0 && !abort_i) |=> drive_o) else $error("drive dropped early"); // R8
    AST_DRIVE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.drive && st_q.cnt == '0) |=> !drive_o) else $error("drive overran"); // R8
endmodule

// File: rtl/hub_dport_evt.sv
module hub_dport_evt #(
    parameter longint unsigned CLK_KHZ        = 48000,
    parameter longint unsigned CONN_AWAKE_NS  = 2500,
    parameter longint unsigned CONN_SUSP_NS   = 5000,
    parameter longint unsigned DISC_AWAKE_NS  = 2250,
    parameter longint unsigned DISC_SUSP_NS   = 4000,
    parameter longint unsigned RSM_DET_NS     = 2500,
    parameter longint unsigned RSM_DRIVE_NS   = 20000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_st_i,
    input  logic       hub_awake_i,
    input  logic       port_en_i,
    output logic       conn_evt_o,
    output logic       disc_evt_o,
    output logic       rsm_bcast_o,
    output logic       rsm_drive_o
);
    import hub_dsp_pkg::*;

    localparam int unsigned CA  = ns_to_cyc(CONN_AWAKE_NS, CLK_KHZ);
    localparam int unsigned CS  = ns_to_cyc(CONN_SUSP_NS, CLK_KHZ);
    localparam int unsigned DA  = ns_to_cyc(DISC_AWAKE_NS, CLK_KHZ);
    localparam int unsigned DS  = ns_to_cyc(DISC_SUSP_NS, CLK_KHZ);
    localparam int unsigned RD  = ns_to_cyc(RSM_DET_NS, CLK_KHZ);
    localparam int unsigned DR  = ns_to_cyc(RSM_DRIVE_NS, CLK_KHZ);
    localparam int unsigned RUN_CAP = max2(max2(max2(CA, CS), max2(DA, DS)), RD) + 1;
    localparam int unsigned RUN_W   = $clog2(RUN_CAP + 1);

    logic [1:0]       line_q;
    logic [RUN_W-1:0] run_q;
    logic             attached, disc_fire;

    hub_dsp_run #(.RUN_CAP(RUN_CAP)) run_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_st_i),
        .line_o (line_q),
        .run_o  (run_q)
    );

    hub_dsp_attach #(.CA(CA), .CS(CS), .DA(DA), .DS(DS), .RUN_CAP(RUN_CAP)) att_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line_q),
        .run_i       (run_q),
        .awake_i     (hub_awake_i),
        .attached_o  (attached),
        .disc_fire_o (disc_fire),
        .conn_o      (conn_evt_o),
        .disc_o      (disc_evt_o)
    );

    hub_dsp_resume #(.RD(RD), .DR(DR), .RUN_CAP(RUN_CAP)) rsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_q),
        .run_i      (run_q),
        .attached_i (attached),
        .awake_i    (hub_awake_i),
        .en_i       (port_en_i),
        .abort_i    (disc_fire),
        .bcast_o    (rsm_bcast_o),
        .drive_o    (rsm_drive_o)
    );

    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({conn_evt_o, disc_evt_o})) else $error("both events"); // R11
    AST_CONN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conn_evt_o |=> !conn_evt_o) else $error("long connect pulse"); // R11
    AST_DISC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        disc_evt_o |=> !disc_evt_o) else $error("long disconnect pulse"); // R11
    AST_BCAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsm_bcast_o |=> !rsm_bcast_o) else $error("long rebroadcast pulse"); // R11
    AST_BCAST_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rsm_bcast_o |-> rsm_drive_o) else $error("rebroadcast without drive"); // R7
    AST_DRIVE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsm_drive_o) |-> rsm_bcast_o) else $error("drive without rebroadcast"); // R7
    AST_DISC_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        disc_evt_o |-> !rsm_drive_o) else $error("drive survives disconnect"); // R10
    AST_CONN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        conn_evt_o |-> $past(line_q != LS_SE0)) else $error("connect on SE0"); // R2
    AST_DISC_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        disc_evt_o |-> $past(line_q == LS_SE0)) else $error("disconnect off SE0"); // R4
endmodule

// File: tb/hub_dport_evt_tb_top.sv
module hub_dport_evt_tb_top;
    localparam longint unsigned KHZ = 2000;
    localparam longint unsigned NS_CA = 2500, NS_CS = 5000, NS_DA = 2250, NS_DS = 4000;
    localparam longint unsigned NS_RD = 2500, NS_DR = 20000;

    function automatic int cyc_of(longint unsigned ns);
        longint unsigned c = (ns * KHZ) / 1000000;
        if (c * 1000000 < ns * KHZ) c = c + 1;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    localparam int CA = cyc_of(NS_CA), CS = cyc_of(NS_CS), DA = cyc_of(NS_DA);
    localparam int DS = cyc_of(NS_DS), RD = cyc_of(NS_RD), DR = cyc_of(NS_DR);
    localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] line = SE0;
    logic awake = 1'b1, en = 1'b0;
    logic conn, disc, bcast, drive;

    always #2 clk = ~clk;

    hub_dport_evt #(.CLK_KHZ(KHZ), .CONN_AWAKE_NS(NS_CA), .CONN_SUSP_NS(NS_CS),
        .DISC_AWAKE_NS(NS_DA), .DISC_SUSP_NS(NS_DS), .RSM_DET_NS(NS_RD),
        .RSM_DRIVE_NS(NS_DR)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_st_i(line), .hub_awake_i(awake),
        .port_en_i(en), .conn_evt_o(conn), .disc_evt_o(disc),
        .rsm_bcast_o(bcast), .rsm_drive_o(drive));

    int cyc = 0;
    int n_chk = 0, n_fail = 0;
    int conn_cnt, disc_cnt, bc_cnt, drv_cnt, conn_cyc, bc_cyc, drv_at_disc, wide_err = 0;
    logic conn_p = 0, disc_p = 0, bc_p = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (conn) begin conn_cnt++; conn_cyc = cyc; end
            if (disc) begin disc_cnt++; drv_at_disc = drive; end
            if (bcast) begin bc_cnt++; bc_cyc = cyc; end
            if (drive) drv_cnt++;
            if ((conn && conn_p) || (disc && disc_p) || (bcast && bc_p) || (conn && disc)) wide_err++;
            conn_p = conn; disc_p = disc; bc_p = bcast;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic hold(input logic [1:0] v, input int n);
        line = v; step(n);
    endtask

    task automatic do_reset(input logic aw, input logic e);
        rst_n = 1'b0; line = SE0; awake = aw; en = e;
        step(3);
        rst_n = 1'b1;
        conn_cnt = 0; disc_cnt = 0; bc_cnt = 0; drv_cnt = 0;
        conn_cyc = -1; bc_cyc = -1; drv_at_disc = -1;
        step(1);
    endtask

    task automatic run_all();
        int c0, thr;
        // R1 reset state
        rst_n = 1'b0; line = K; step(2);
        chk({conn, disc, bcast, drive} == 4'b0, "R1 outputs in reset", {conn, disc, bcast, drive}, 0);
        do_reset(1'b1, 1'b0);
        chk({conn, disc, bcast, drive} == 4'b0, "R1 outputs after reset", {conn, disc, bcast, drive}, 0);

        // R2 / R3 connect sweep
        for (int aw = 1; aw >= 0; aw--) begin
            thr = aw ? CA : CS;
            for (int n = thr - 2; n <= thr + 1; n++) begin
                do_reset(aw[0], 1'b0);
                c0 = cyc;
                hold((n % 2) ? J : K, n);
                hold(SE0, 3);
                chk(conn_cnt == ((n >= thr) ? 1 : 0), aw ? "R2 connect count" : "R3 connect count",
                    conn_cnt, (n >= thr) ? 1 : 0);
                if (n >= thr)
                    chk(conn_cyc == c0 + thr + 1, aw ? "R2 connect cycle" : "R3 connect cycle",
                        conn_cyc, c0 + thr + 1);
            end
        end

        // R4 / R5 disconnect sweep
        for (int aw = 1; aw >= 0; aw--) begin
            thr = aw ? DA : DS;
            for (int n = thr - 2; n <= thr + 1; n++) begin
                do_reset(aw[0], 1'b0);
                hold(J, CS + 1);
                hold(SE0, n);
                hold(J, 2);
                chk(disc_cnt == ((n >= thr) ? 1 : 0), aw ? "R4 disconnect count" : "R5 disconnect count",
                    disc_cnt, (n >= thr) ? 1 : 0);
            end
        end

        // R6 restart on change
        do_reset(1'b1, 1'b0);
        hold(J, CA - 1); hold(K, CA - 1); hold(J, CA - 1); hold(SE0, 3);
        chk(conn_cnt == 0, "R6 J/K toggling restarts connect", conn_cnt, 0);
        c0 = cyc;
        hold(J, CA + 2);
        chk(conn_cnt == 1 && conn_cyc == c0 + CA + 1, "R6 connect after restart", conn_cyc, c0 + CA + 1);
        hold(SE0, DA - 1); hold(J, 1); hold(SE0, DA - 1); hold(J, 3);
        chk(disc_cnt == 0, "R6 broken SE0 restarts disconnect", disc_cnt, 0);

        // R7 / R8 resume
        do_reset(1'b1, 1'b1);
        hold(J, CS + 1);
        awake = 1'b0;
        hold(J, 3);
        hold(K, RD - 1); hold(J, 3);
        chk(bc_cnt == 0 && drv_cnt == 0, "R7 short K no resume", bc_cnt, 0);
        c0 = cyc;
        hold(K, RD + DR + 6);
        chk(bc_cnt == 1, "R7 rebroadcast count", bc_cnt, 1);
        chk(bc_cyc == c0 + RD + 1, "R7 rebroadcast cycle", bc_cyc, c0 + RD + 1);
        chk(drv_cnt == DR, "R8 drive length", drv_cnt, DR);
        chk(drive == 1'b0, "R8 drive ended with K held", drive, 0);
        hold(J, 3);

        // R9 ignored cases
        do_reset(1'b1, 1'b1);
        hold(J, CS + 1);
        hold(K, RD + 4);
        chk(bc_cnt == 0 && drv_cnt == 0, "R9 hub awake", bc_cnt, 0);
        do_reset(1'b1, 1'b0);
        hold(J, CS + 1);
        awake = 1'b0; hold(J, 2);
        hold(K, RD + 4);
        chk(bc_cnt == 0 && drv_cnt == 0, "R9 port disabled", bc_cnt, 0);
        do_reset(1'b0, 1'b1);
        hold(K, CS + RD + 4);
        chk(bc_cnt == 0 && conn_cnt == 1, "R9 detached at K threshold", bc_cnt, 0);

        // R10 disconnect during drive
        do_reset(1'b1, 1'b1);
        hold(J, CS + 1);
        awake = 1'b0; hold(J, 3);
        hold(K, RD + 4);
        chk(drive == 1'b1, "R10 drive active", drive, 1);
        hold(SE0, DS + 2);
        chk(disc_cnt == 1, "R10 disconnect reported", disc_cnt, 1);
        chk(drv_at_disc == 0 && drive == 1'b0, "R10 drive aborted", drv_at_disc, 0);
        chk(drv_cnt < DR, "R10 drive shortened", drv_cnt, DR - 1);

        // R11 pulse width
        chk(wide_err == 0, "R11 single-cycle pulses", wide_err, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule